// File: doc/BRIEF.md
# Fabric Address Rebase Bridge

This block sits in the fabric between a 64-bit CPU address space and a root port whose address ports are 32 bits wide. It carries only addresses; data beats are handled elsewhere. Each direction has a one-entry registered stage with a valid/ready handshake on both sides.

Addresses going toward the CPU (inbound) arrive as 32-bit intermediate addresses. The bridge removes a base that depends on the coherency mode. In coherent mode the base is 0 and the window covers the full 4 GiB. In non-coherent mode the base is 0x8000_0000 and the window covers 2 GiB. The bridge then adds a programmable 64-bit target offset. Addresses going toward the root port (outbound) are 64-bit CPU addresses. The bridge checks their upper half against a programmed value and passes on only the lower 32 bits.

A small write port loads the target offset, the mode and the outbound upper-half match value. Each address is translated with the configuration that was in force when the bridge accepted it.

Top module: `addr_rebase_bridge`

## Requirements
- R1: After reset, both output valids are 0 and both input readies are 1. The reset configuration is: target offset 0, coherent mode, outbound match value 0.
- R2: In coherent mode, an accepted inbound address A gives inbOutAddr = target + A with inbOutErr = 0, for every A from 0x0000_0000 to 0xFFFF_FFFF.
- R3: In non-coherent mode, an accepted inbound address A with A >= 0x8000_0000 gives inbOutAddr = target + (A - 0x8000_0000) with inbOutErr = 0.
- R4: In non-coherent mode, an inbound address below 0x8000_0000 produces an output beat with inbOutErr = 1 and inbOutAddr = 0.
- R5: An outbound address whose bits [63:32] equal the match value produces obOutAddr = bits [31:0] with obOutErr = 0.
- R6: An outbound address whose bits [63:32] differ from the match value produces an output beat with obOutErr = 1 and obOutAddr = 0. The address itself is not forwarded.
- R7: A write with cfgWrEn = 1 loads one register chosen by cfgSel. The encodings are:
  - cfgSel = 0: target bits [31:0].
  - cfgSel = 1: target bits [63:32].
  - cfgSel = 2: mode, from cfgWrData[0] (1 = non-coherent).
  - cfgSel = 3: outbound match value.

  A write applies to addresses accepted in later cycles. An address accepted in the same cycle as the write uses the old value.
- R8: An input beat is accepted on a clock edge where valid and ready are both 1, and its result is valid after that edge. Each input ready equals the inverse of its output valid ORed with its output ready.
- R9: While an output is valid and its ready is 0, the output valid, address and error flag hold their values.
- R10: The target addition is a full 64-bit addition. It carries into bits [63:32] and wraps modulo 2^64.
- R11: The two directions are independent: a stall in one does not block the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgSel | input | 2 | Configuration register select |
| cfgWrData | input | 32 | Configuration write data |
| inValid | input | 1 | Inbound address valid |
| inReady | output | 1 | Inbound address ready |
| inAddr | input | 32 | Inbound intermediate address |
| inbOutValid | output | 1 | Translated inbound address valid |
| inbOutReady | input | 1 | Translated inbound address ready |
| inbOutAddr | output | 64 | Translated 64-bit address |
| inbOutErr | output | 1 | Inbound decode error |
| obValid | input | 1 | Outbound CPU address valid |
| obReady | output | 1 | Outbound CPU address ready |
| obAddr | input | 64 | Outbound CPU address |
| obOutValid | output | 1 | Forwarded outbound address valid |
| obOutReady | input | 1 | Forwarded outbound address ready |
| obOutAddr | output | 32 | Forwarded lower 32 bits |
| obOutErr | output | 1 | Outbound decode error |

## Verification
The inbound path is tested with addresses at both edges of each window and with the first address just below the non-coherent base. These show whether the base subtraction and the window compare are placed correctly. A target offset chosen so the sum crosses the 32-bit boundary, and one chosen so it wraps past 2^64, separate a true 64-bit addition from a concatenation or a truncated sum. Outbound addresses with a matching upper half and with two different mismatching upper halves separate correct forwarding from a compare that ignores some bits. Two timing tests complete the set: a configuration write in the same cycle as an accept, and a stalled output that must not block the other direction. They separate capture at the accept from capture at any other point.

// File: rtl/rebase_pkg.sv
`timescale 1ns/1ps
package rebase_pkg;
  localparam logic [1:0] CFG_TGT_LO = 2'd0;
  localparam logic [1:0] CFG_TGT_HI = 2'd1;
  localparam logic [1:0] CFG_MODE   = 2'd2;
  localparam logic [1:0] CFG_UPPER  = 2'd3;

  localparam int CH_INB = 0;
  localparam int CH_OB  = 1;

  typedef struct packed {
    logic inbLoad;
    logic obLoad;
    logic wrTgtLo;
    logic wrTgtHi;
    logic wrMode;
    logic wrUpper;
  } ctrlStrobes_t;
endpackage

// File: rtl/rebase_ctrl.sv
`timescale 1ns/1ps
module rebase_ctrl
  import rebase_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [1:0]        cfgSel,
  input  logic [NUM_CH-1:0] srcValid,
  output logic [NUM_CH-1:0] srcReady,
  output logic [NUM_CH-1:0] dstValid,
  input  logic [NUM_CH-1:0] dstReady,
  output ctrlStrobes_t      strobes
);
  logic [NUM_CH-1:0] take;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic vldQ;
    assign srcReady[c] = !vldQ || dstReady[c];
    assign take[c]     = srcValid[c] && srcReady[c];
    assign dstValid[c] = vldQ;
    always_ff @(posedge clk) begin
      if (!rstN)            vldQ <= 1'b0;
      else if (srcReady[c]) vldQ <= srcValid[c];
    end
  end

  always_comb begin
    strobes         = '0;
    strobes.inbLoad = take[CH_INB];
    strobes.obLoad  = take[CH_OB];
    strobes.wrTgtLo = cfgWrEn && (cfgSel == CFG_TGT_LO);
    strobes.wrTgtHi = cfgWrEn && (cfgSel == CFG_TGT_HI);
    strobes.wrMode  = cfgWrEn && (cfgSel == CFG_MODE);
    strobes.wrUpper = cfgWrEn && (cfgSel == CFG_UPPER);
  end
endmodule

// File: rtl/rebase_datapath.sv
`timescale 1ns/1ps
module rebase_datapath
  import rebase_pkg::*;
#(
  parameter int              IN_W    = 32,
  parameter int              CPU_W   = 64,
  parameter logic [IN_W-1:0] NC_BASE = 32'h8000_0000
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strobes,
  input  logic [IN_W-1:0]  cfgWrData,
  input  logic [IN_W-1:0]  inAddr,
  input  logic [CPU_W-1:0] obAddr,
  output logic [CPU_W-1:0] inbOutAddr,
  output logic             inbOutErr,
  output logic [IN_W-1:0]  obOutAddr,
  output logic             obOutErr
);
  // Upper part of the CPU address; must fit in one config word.
  localparam int UP_W = CPU_W - IN_W;

  logic [IN_W-1:0]  tgtLo;
  logic [UP_W-1:0]  tgtHi;
  logic             ncMode;
  logic [UP_W-1:0]  upperMatch;

  logic             inWin;
  logic [IN_W-1:0]  inOff;
  logic [CPU_W-1:0] inbNext;
  logic             obHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tgtLo      <= '0;
      tgtHi      <= '0;
      ncMode     <= 1'b0;
      upperMatch <= '0;
    end else begin
      if (strobes.wrTgtLo) tgtLo      <= cfgWrData;
      if (strobes.wrTgtHi) tgtHi      <= cfgWrData[UP_W-1:0];
      if (strobes.wrMode)  ncMode     <= cfgWrData[0];
      if (strobes.wrUpper) upperMatch <= cfgWrData[UP_W-1:0];
    end
  end

  // Inbound: window compare, rebase, then 64-bit offset add.
  always_comb begin
    inWin   = !ncMode || (inAddr >= NC_BASE);
    inOff   = ncMode ? (inAddr - NC_BASE) : inAddr;
    inbNext = {tgtHi, tgtLo} + CPU_W'(inOff);
  end

  // Outbound: upper half must match the programmed value.
  assign obHit = (obAddr[CPU_W-1:IN_W] == upperMatch);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inbOutAddr <= '0;
      inbOutErr  <= 1'b0;
      obOutAddr  <= '0;
      obOutErr   <= 1'b0;
    end else begin
      if (strobes.inbLoad) begin
        inbOutAddr <= inWin ? inbNext : '0;
        inbOutErr  <= !inWin;
      end
      if (strobes.obLoad) begin
        obOutAddr <= obHit ? obAddr[IN_W-1:0] : '0;
        obOutErr  <= !obHit;
      end
    end
  end
endmodule

// File: rtl/addr_rebase_bridge.sv
`timescale 1ns/1ps
module addr_rebase_bridge
  import rebase_pkg::*;
#(
  parameter int              IN_W    = 32,
  parameter int              CPU_W   = 64,
  parameter logic [IN_W-1:0] NC_BASE = 32'h8000_0000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [1:0]       cfgSel,
  input  logic [IN_W-1:0]  cfgWrData,
  input  logic             inValid,
  output logic             inReady,
  input  logic [IN_W-1:0]  inAddr,
  output logic             inbOutValid,
  input  logic             inbOutReady,
  output logic [CPU_W-1:0] inbOutAddr,
  output logic             inbOutErr,
  input  logic             obValid,
  output logic             obReady,
  input  logic [CPU_W-1:0] obAddr,
  output logic             obOutValid,
  input  logic             obOutReady,
  output logic [IN_W-1:0]  obOutAddr,
  output logic             obOutErr
);
  localparam int NUM_CH = 2;

  ctrlStrobes_t      strobes;
  logic [NUM_CH-1:0] srcReady;
  logic [NUM_CH-1:0] dstValid;

  assign inReady     = srcReady[CH_INB];
  assign obReady     = srcReady[CH_OB];
  assign inbOutValid = dstValid[CH_INB];
  assign obOutValid  = dstValid[CH_OB];

  rebase_ctrl #(.NUM_CH(NUM_CH)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWrEn  (cfgWrEn),
    .cfgSel   (cfgSel),
    .srcValid ({obValid, inValid}),
    .srcReady (srcReady),
    .dstValid (dstValid),
    .dstReady ({obOutReady, inbOutReady}),
    .strobes  (strobes)
  );

  rebase_datapath #(.IN_W(IN_W), .CPU_W(CPU_W), .NC_BASE(NC_BASE)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .cfgWrData  (cfgWrData),
    .inAddr     (inAddr),
    .obAddr     (obAddr),
    .inbOutAddr (inbOutAddr),
    .inbOutErr  (inbOutErr),
    .obOutAddr  (obOutAddr),
    .obOutErr   (obOutErr)
  );
endmodule

// File: rtl/rebase_checker.sv
`timescale 1ns/1ps
module rebase_checker #(
  parameter int IN_W  = 32,
  parameter int CPU_W = 64
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic             inReady,
  input logic             inbOutValid,
  input logic             inbOutReady,
  input logic [CPU_W-1:0] inbOutAddr,
  input logic             inbOutErr,
  input logic             obValid,
  input logic             obReady,
  input logic             obOutValid,
  input logic             obOutReady,
  input logic [IN_W-1:0]  obOutAddr,
  input logic             obOutErr
);
  AST_INB_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady |=> inbOutValid); // R8
  AST_OB_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    obValid && obReady |=> obOutValid); // R8
  AST_INB_BACKPRESSURE: assert property (@(posedge clk) disable iff (!rstN)
    inbOutValid && !inbOutReady |-> !inReady); // R8
  AST_INB_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    inbOutValid && !inbOutReady |=> inbOutValid && $stable(inbOutAddr) && $stable(inbOutErr)); // R9
  AST_OB_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    obOutValid && !obOutReady |=> obOutValid && $stable(obOutAddr) && $stable(obOutErr)); // R9
  AST_INB_ERR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    inbOutValid && inbOutErr |-> inbOutAddr == '0); // R4
  AST_OB_ERR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    obOutValid && obOutErr |-> obOutAddr == '0); // R6
endmodule

bind addr_rebase_bridge rebase_checker #(.IN_W(IN_W), .CPU_W(CPU_W)) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .inValid     (inValid),
  .inReady     (inReady),
  .inbOutValid (inbOutValid),
  .inbOutReady (inbOutReady),
  .inbOutAddr  (inbOutAddr),
  .inbOutErr   (inbOutErr),
  .obValid     (obValid),
  .obReady     (obReady),
  .obOutValid  (obOutValid),
  .obOutReady  (obOutReady),
  .obOutAddr   (obOutAddr),
  .obOutErr    (obOutErr)
);

// File: tb/addr_rebase_bridge_test.sv
`timescale 1ns/1ps
module addr_rebase_bridge_test;
  localparam int WATCHDOG_CYCLES = 20000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [1:0]  cfgSel = '0;
  logic [31:0] cfgWrData = '0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [31:0] inAddr = '0;
  logic        inbOutValid;
  logic        inbOutReady = 1'b1;
  logic [63:0] inbOutAddr;
  logic        inbOutErr;
  logic        obValid = 1'b0;
  logic        obReady;
  logic [63:0] obAddr = '0;
  logic        obOutValid;
  logic        obOutReady = 1'b1;
  logic [31:0] obOutAddr;
  logic        obOutErr;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk; // 8 ns period, 125 MHz

  addr_rebase_bridge uut (.*);

  typedef struct packed {
    logic        nc;
    logic        carry;
    logic [63:0] tgt;
    logic [31:0] addr;
    logic [63:0] exp;
    logic        err;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 1'b0, 64'h10_0000_0000,         32'h0000_0000, 64'h10_0000_0000,         1'b0},
    '{1'b0, 1'b0, 64'h10_0000_0000,         32'hFFFF_FFFF, 64'h10_FFFF_FFFF,         1'b0},
    '{1'b1, 1'b0, 64'h10_0000_0000,         32'h8000_0000, 64'h10_0000_0000,         1'b0},
    '{1'b1, 1'b0, 64'h10_0000_0000,         32'hFFFF_FFFF, 64'h10_7FFF_FFFF,         1'b0},
    '{1'b1, 1'b0, 64'h10_0000_0000,         32'h7FFF_FFFF, 64'h0,                    1'b1},
    '{1'b1, 1'b0, 64'h10_0000_0000,         32'h0000_0000, 64'h0,                    1'b1},
    '{1'b0, 1'b1, 64'h1_8000_0000,          32'h9000_0000, 64'h2_1000_0000,          1'b0},
    '{1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FFF0,  32'h0000_0020, 64'h10,                   1'b0},
    '{1'b1, 1'b1, 64'hFFFF_FFFF,            32'h8000_0001, 64'h1_0000_0000,          1'b0}
  };

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgSel = sel; cfgWrData = data;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic sendInb(input logic [31:0] a);
    @(negedge clk);
    inValid = 1'b1; inAddr = a;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic sendOb(input logic [63:0] a);
    @(negedge clk);
    obValid = 1'b1; obAddr = a;
    @(negedge clk);
    obValid = 1'b0;
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state at the ports
    check(!inbOutValid && !obOutValid, "R1 valids", {62'd0, inbOutValid, obOutValid}, 64'd0);
    check(inReady && obReady, "R1 readies", {62'd0, inReady, obReady}, 64'd3);
    sendInb(32'h0000_1234);
    check(inbOutValid && !inbOutErr && inbOutAddr == 64'h1234, "R1 default inbound", inbOutAddr, 64'h1234);
    sendOb(64'h0000_0000_CAFE_0000);
    check(obOutValid && !obOutErr && obOutAddr == 32'hCAFE_0000, "R1 default outbound", {32'd0, obOutAddr}, 64'hCAFE_0000);

    // Table walk: R2, R3, R4, R10 (and R7 register map)
    for (int i = 0; i < NVEC; i++) begin
      string tag;
      cfgWrite(2'd0, VECS[i].tgt[31:0]);
      cfgWrite(2'd1, VECS[i].tgt[63:32]);
      cfgWrite(2'd2, {31'd0, VECS[i].nc});
      sendInb(VECS[i].addr);
      tag = VECS[i].carry ? "R10" : VECS[i].err ? "R4" : VECS[i].nc ? "R3" : "R2";
      check(inbOutValid && inbOutAddr == VECS[i].exp && inbOutErr == VECS[i].err,
            $sformatf("%s R7 vector %0d", tag, i), inbOutAddr, VECS[i].exp);
    end

    // R5 / R6: outbound match and mismatch
    cfgWrite(2'd3, 32'h0000_0010);
    sendOb(64'h10_DEAD_BEEF);
    check(obOutValid && !obOutErr && obOutAddr == 32'hDEAD_BEEF, "R5 match", {32'd0, obOutAddr}, 64'hDEAD_BEEF);
    sendOb(64'h11_DEAD_BEEF);
    check(obOutValid && obOutErr && obOutAddr == 32'd0, "R6 mismatch high", {31'd0, obOutErr, obOutAddr}, 64'h1_0000_0000);
    sendOb(64'h0_0000_1234);
    check(obOutValid && obOutErr && obOutAddr == 32'd0, "R6 mismatch zero", {31'd0, obOutErr, obOutAddr}, 64'h1_0000_0000);

    // R7: write in the same cycle as an accept uses the old mode
    cfgWrite(2'd0, 32'd0);
    cfgWrite(2'd1, 32'd0);
    cfgWrite(2'd2, 32'd0);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgSel = 2'd2; cfgWrData = 32'd1;
    inValid = 1'b1; inAddr = 32'h100;
    @(negedge clk);
    cfgWrEn = 1'b0; inValid = 1'b0;
    check(inbOutValid && !inbOutErr && inbOutAddr == 64'h100, "R7 same-cycle old mode", inbOutAddr, 64'h100);
    sendInb(32'h100);
    check(inbOutValid && inbOutErr, "R7 next accept new mode", {63'd0, inbOutErr}, 64'd1);

    // R8 / R9 / R11: stall inbound output, outbound keeps flowing
    cfgWrite(2'd2, 32'd0);
    @(negedge clk);
    inbOutReady = 1'b0; inValid = 1'b1; inAddr = 32'hAAAA_0000;
    @(negedge clk);
    check(inbOutValid && inbOutAddr == 64'hAAAA_0000, "R8 latency", inbOutAddr, 64'hAAAA_0000);
    check(!inReady, "R8 backpressure", {63'd0, inReady}, 64'd0);
    inAddr = 32'hBBBB_0000;
    obValid = 1'b1; obAddr = 64'h10_0000_5555;
    @(negedge clk);
    obValid = 1'b0;
    check(inbOutValid && inbOutAddr == 64'hAAAA_0000, "R9 hold", inbOutAddr, 64'hAAAA_0000);
    check(obOutValid && !obOutErr && obOutAddr == 32'h5555, "R11 outbound during stall", {32'd0, obOutAddr}, 64'h5555);
    inbOutReady = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check(inbOutValid && inbOutAddr == 64'hBBBB_0000, "R8 release", inbOutAddr, 64'hBBBB_0000);
    @(negedge clk);
    check(!inbOutValid, "R8 drained", {63'd0, inbOutValid}, 64'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule